// File: doc/BRIEF.md
# Line Clamp Pulse Timing Generator

This block times the black-level clamp strobe of a video digitizer front end, with all timing counted in pixel clocks. In internal mode it waits for the trailing edge of horizontal sync. That edge is the change of hsync from its active level to its idle level. The block then lets a programmed number of settling pixels pass and raises the clamp strobe for a programmed number of pixels. The window sits in the back porch, where the source is known to send black.

In external mode the strobe instead follows an external clamp pin. A polarity bit says which level of that pin means "clamp". The block also gives one target code per colour channel. Red and blue can each choose midscale (0x80) or ground (0x00), for sources whose reference level sits mid-range. Green always uses ground.

Placement, duration and the two target selects are sampled when the block acts on a trailing edge. A change made in the middle of a line therefore waits for the next line. The hsync input passes through a two-flop synchronizer before its edges are detected.

Top module: `line_clamp_gen`

## Requirements
- R1: While reset is held and after its release, clamp_o is 0 in internal mode and all three target codes read 0x00 until the first trailing edge has been acted on.
- R2: cfg_hs_pol=1 makes high the active hsync level and cfg_hs_pol=0 makes low the active level. Only an active-to-idle change of hs_in starts a window. An idle-to-active change starts nothing.
- R3: In internal mode, suppose hs_in makes its trailing change before clock edge k. Then clamp_o first reads 1 after edge k+2+P, where P is the 8-bit placement value cfg_place. P=0 is allowed.
- R4: The strobe stays high for exactly D clock cycles, where D is the 8-bit value cfg_dur, and then returns to 0.
- R5: With D=0 no strobe is produced for that line.
- R6: A trailing edge that arrives while a window is pending or high abandons that window. The placement count restarts from the new edge, and the old window ends at the cycle the new one is loaded.
- R7: cfg_place, cfg_dur, cfg_red_mid and cfg_blu_mid are sampled at the clock edge k+2 of a trailing edge. Changes made at other times do not alter a window already started or the target codes already shown.
- R8: With cfg_ext_mode=1, clamp_o combinationally equals ext_clamp_in when cfg_ext_pol=1 and its inverse when cfg_ext_pol=0. The internal window has no effect on the output.
- R9: red_target_o reads 0x80 when the sampled red select is 1 and 0x00 when it is 0. blu_target_o does the same from the blue select. grn_target_o always reads 0x00. The red and blue codes change only at edge k+2 of a trailing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hs_in | input | 1 | Horizontal sync, asynchronous |
| ext_clamp_in | input | 1 | External clamp request |
| cfg_hs_pol | input | 1 | 1: hsync active high, 0: active low |
| cfg_ext_mode | input | 1 | 1: external clamp drives clamp_o |
| cfg_ext_pol | input | 1 | 1: external clamp active high |
| cfg_place | input | 8 | Settling pixels after the trailing edge |
| cfg_dur | input | 8 | Clamp width in pixels |
| cfg_red_mid | input | 1 | 1: red target midscale |
| cfg_blu_mid | input | 1 | 1: blue target midscale |
| clamp_o | output | 1 | Clamp strobe, active high |
| red_target_o | output | 8 | Red clamp target code |
| grn_target_o | output | 8 | Green clamp target code |
| blu_target_o | output | 8 | Blue clamp target code |

## Verification
The hard case is a new trailing edge landing while an earlier window is still counting down. The reload from the new edge and the expiry or the wait-to-hold step of the old window then fall on the same clock edge. Random line lengths, with sync gaps often shorter than placement plus duration, place new edges in the wait phase, in the hold phase and on the hold's last cycle. A directed pair of lines forces the same collision on purpose. In every case the bench predicts the strobe only from the latest edge whose load cycle has passed, so a strobe from the old window that lingers or is cut short shows up as a mismatch.

// File: rtl/clampgen_pkg.sv
package clampgen_pkg;
  localparam int CODE_W = 8;

  typedef enum logic [1:0] {
    CW_IDLE = 2'd0,
    CW_WAIT = 2'd1,
    CW_HOLD = 2'd2
  } cw_state_e;

  function automatic logic level_active(input logic lvl, input logic act_high);
    return lvl == act_high;
  endfunction

  function automatic logic [CODE_W-1:0] clamp_code(input logic midscale);
    return midscale ? CODE_W'(8'h80) : '0;
  endfunction

  function automatic logic [7:0] count_from(input logic [7:0] span);
    return span - 8'd1;
  endfunction
endpackage

// File: rtl/hs_edge_det.sv
module hs_edge_det
  import clampgen_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_raw_i,
  input  logic hs_pol_i,
  output logic trail_o,
  output logic lead_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   hist_q;
  logic [SYNC_STAGES:0]   fill_q;
  logic                   primed;
  logic                   now_act;
  logic                   was_act;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[s] <= 1'b0;
      else if (s == 0) sync_q[s] <= hs_raw_i;
      else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= 1'b0;
      fill_q <= '0;
    end else begin
      hist_q <= sync_q[SYNC_STAGES-1];
      fill_q <= {fill_q[SYNC_STAGES-1:0], 1'b1};
    end
  end

  assign primed  = fill_q[SYNC_STAGES];
  assign now_act = level_active(sync_q[SYNC_STAGES-1], hs_pol_i);
  assign was_act = level_active(hist_q, hs_pol_i);
  assign trail_o = primed && was_act && !now_act;
  assign lead_o  = primed && !was_act && now_act;

  // R2
  trail_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trail_o |=> !trail_o);
endmodule

// File: rtl/clamp_window_timer.sv
module clamp_window_timer
  import clampgen_pkg::*;
#(
  parameter int         CNT_W   = 8,
  parameter logic [7:0] DUR_DEF = 8'h14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] place_i,
  input  logic [CNT_W-1:0] dur_i,
  output logic             hold_o
);
  cw_state_e        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] dur_q;
  logic             wait_done;
  logic             hold_done;

  assign wait_done = (st_q == CW_WAIT) && (cnt_q == '0);
  assign hold_done = (st_q == CW_HOLD) && (cnt_q == '0);
  assign hold_o    = (st_q == CW_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CW_IDLE;
      cnt_q <= '0;
      dur_q <= CNT_W'(DUR_DEF);
    end else if (start_i) begin
      dur_q <= dur_i;
      if (place_i != '0) begin
        st_q  <= CW_WAIT;
        cnt_q <= CNT_W'(count_from(8'(place_i)));
      end else if (dur_i != '0) begin
        st_q  <= CW_HOLD;
        cnt_q <= CNT_W'(count_from(8'(dur_i)));
      end else begin
        st_q  <= CW_IDLE;
        cnt_q <= '0;
      end
    end else begin
      case (st_q)
        CW_WAIT: begin
          if (wait_done) begin
            if (dur_q != '0) begin
              st_q  <= CW_HOLD;
              cnt_q <= CNT_W'(count_from(8'(dur_q)));
            end else begin
              st_q <= CW_IDLE;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        CW_HOLD: begin
          if (hold_done) st_q <= CW_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= CW_IDLE;
      endcase
    end
  end

  // R5
  dur_zero_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CW_HOLD) |-> (dur_q != '0));
  // R4
  hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CW_HOLD) |-> (cnt_q < dur_q));
  // R4
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CW_HOLD && cnt_q != '0 && !start_i) |=> (st_q == CW_HOLD));
  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && place_i != '0) |=> (st_q == CW_WAIT && cnt_q == $past(place_i) - 1'b1));
  // R3
  wait_to_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_done && dur_q != '0 && !start_i) |=> (st_q == CW_HOLD));
endmodule

// File: rtl/line_clamp_gen.sv
module line_clamp_gen
  import clampgen_pkg::*;
#(
  parameter int         CNT_W       = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] DUR_DEF     = 8'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_in,
  input  logic              ext_clamp_in,
  input  logic              cfg_hs_pol,
  input  logic              cfg_ext_mode,
  input  logic              cfg_ext_pol,
  input  logic [CNT_W-1:0]  cfg_place,
  input  logic [CNT_W-1:0]  cfg_dur,
  input  logic              cfg_red_mid,
  input  logic              cfg_blu_mid,
  output logic              clamp_o,
  output logic [CODE_W-1:0] red_target_o,
  output logic [CODE_W-1:0] grn_target_o,
  output logic [CODE_W-1:0] blu_target_o
);
  logic trail_ev;
  logic lead_ev;
  logic win_hold;
  logic ext_req;
  logic red_mid_q;
  logic blu_mid_q;

  hs_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .hs_raw_i (hs_in),
    .hs_pol_i (cfg_hs_pol),
    .trail_o  (trail_ev),
    .lead_o   (lead_ev)
  );

  clamp_window_timer #(.CNT_W(CNT_W), .DUR_DEF(DUR_DEF)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (trail_ev),
    .place_i (cfg_place),
    .dur_i   (cfg_dur),
    .hold_o  (win_hold)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      red_mid_q <= 1'b0;
      blu_mid_q <= 1'b0;
    end else if (trail_ev) begin
      red_mid_q <= cfg_red_mid;
      blu_mid_q <= cfg_blu_mid;
    end
  end

  assign ext_req      = level_active(ext_clamp_in, cfg_ext_pol);
  assign clamp_o      = cfg_ext_mode ? ext_req : win_hold;
  assign red_target_o = clamp_code(red_mid_q);
  assign blu_target_o = clamp_code(blu_mid_q);
  assign grn_target_o = clamp_code(1'b0);

  // R9
  target_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trail_ev |=> ($stable(red_target_o) && $stable(blu_target_o)));
  // R2
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lead_ev |=> !trail_ev);
  // R8
  ext_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ext_mode && $past(cfg_ext_mode) && $stable(ext_clamp_in) && $stable(cfg_ext_pol))
      |-> $stable(clamp_o));
endmodule

// File: tb/test_line_clamp_gen.sv
`timescale 1ns/1ps
module test_line_clamp_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs_in = 1'b0;
  logic ext_clamp_in = 1'b0;
  logic cfg_hs_pol = 1'b1;
  logic cfg_ext_mode = 1'b0;
  logic cfg_ext_pol = 1'b1;
  logic [7:0] cfg_place = 8'h08;
  logic [7:0] cfg_dur = 8'h14;
  logic cfg_red_mid = 1'b0;
  logic cfg_blu_mid = 1'b0;
  logic clamp_o;
  logic [7:0] red_target_o, grn_target_o, blu_target_o;

  line_clamp_gen i_line_clamp_gen (
    .clk(clk), .rst_n(rst_n), .hs_in(hs_in), .ext_clamp_in(ext_clamp_in),
    .cfg_hs_pol(cfg_hs_pol), .cfg_ext_mode(cfg_ext_mode), .cfg_ext_pol(cfg_ext_pol),
    .cfg_place(cfg_place), .cfg_dur(cfg_dur), .cfg_red_mid(cfg_red_mid),
    .cfg_blu_mid(cfg_blu_mid), .clamp_o(clamp_o), .red_target_o(red_target_o),
    .grn_target_o(grn_target_o), .blu_target_o(blu_target_o)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string tag = "R1";

  bit pend_v = 0; int pend_load = 0; int pend_p = 0, pend_d = 0; bit pend_r = 0, pend_b = 0;
  bit cur_v = 0;  int cur_start = 0; int cur_p = 0, cur_d = 0;
  bit exp_r = 0, exp_b = 0;

  function automatic bit in_window(int m, int s, int p, int d);
    return (d != 0) && (m >= s + p) && (m < s + p + d);
  endfunction

  function automatic logic [7:0] code_of(bit mid);
    return mid ? 8'h80 : 8'h00;
  endfunction

  task automatic check_now();
    bit e;
    int m = cyc;
    if (pend_v && m >= pend_load) begin
      cur_v = 1; cur_start = pend_load; cur_p = pend_p; cur_d = pend_d;
      exp_r = pend_r; exp_b = pend_b; pend_v = 0;
    end
    if (cfg_ext_mode) e = (ext_clamp_in == cfg_ext_pol);
    else e = cur_v && in_window(m, cur_start, cur_p, cur_d);
    n_chk++;
    if (clamp_o !== e) begin
      n_bad++;
      $display("FAIL %s clamp (R3 R4 R5 R8) cyc %0d: got %b exp %b", tag, m, clamp_o, e);
    end
    n_chk++;
    if (red_target_o !== code_of(exp_r) || blu_target_o !== code_of(exp_b) || grn_target_o !== 8'h00) begin
      n_bad++;
      $display("FAIL R9 %s targets cyc %0d: got %h/%h/%h exp %h/%h/00", tag, m,
               red_target_o, grn_target_o, blu_target_o, code_of(exp_r), code_of(exp_b));
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_now();
    end
  endtask

  task automatic set_hs(bit v);
    if (hs_in == cfg_hs_pol && v != cfg_hs_pol) begin
      pend_v = 1; pend_load = cyc + 3;
      pend_p = cfg_place; pend_d = cfg_dur; pend_r = cfg_red_mid; pend_b = cfg_blu_mid;
    end
    hs_in = v;
  endtask

  task automatic line(int w, int gap);
    set_hs(cfg_hs_pol); tick(w);
    set_hs(!cfg_hs_pol); tick(gap);
  endtask

  task automatic set_cfg(int p, int d, bit r, bit b);
    cfg_place = 8'(p); cfg_dur = 8'(d); cfg_red_mid = r; cfg_blu_mid = b;
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired: got hang exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    hs_in = 1'b0;
    tag = "R1";
    repeat (4) @(negedge clk);
    n_chk++;
    if (clamp_o !== 1'b0 || red_target_o !== 8'h00 || blu_target_o !== 8'h00) begin
      n_bad++; $display("FAIL R1 in reset: got %b %h %h exp 0 00 00", clamp_o, red_target_o, blu_target_o);
    end
    rst_n = 1'b1;
    tick(8);

    tag = "R3";
    set_cfg(8, 20, 0, 0); line(4, 40);
    set_cfg(0, 1, 1, 0); line(3, 10);
    set_cfg(255, 3, 0, 1); line(2, 270);
    tag = "R5";
    set_cfg(4, 0, 1, 1); line(5, 20);
    set_cfg(0, 0, 0, 0); line(5, 12);

    tag = "R6";
    set_cfg(10, 10, 0, 0); line(3, 6); line(3, 30);
    set_cfg(2, 10, 1, 0); line(3, 8); line(2, 25);
    set_cfg(1, 4, 0, 1); line(2, 4); line(2, 20);

    tag = "R7";
    set_cfg(3, 12, 0, 0); line(3, 6);
    set_cfg(1, 2, 1, 1); tick(15);
    line(3, 12);

    tag = "R2";
    set_cfg(5, 6, 0, 0); tick(4);
    cfg_hs_pol = 1'b0; tick(4);
    line(4, 20);
    set_hs(1'b0); tick(30);
    set_hs(1'b1); tick(20);
    cfg_hs_pol = 1'b1; tick(4);
    set_hs(1'b0); tick(20);

    tag = "R8";
    cfg_ext_mode = 1'b1;
    for (int i = 0; i < 60; i++) begin
      ext_clamp_in = $urandom_range(0, 1);
      if (i == 30) cfg_ext_pol = 1'b0;
      if (i == 10) set_hs(1'b1);
      if (i == 14) set_hs(1'b0);
      tick(1);
    end
    cfg_ext_mode = 1'b0; cfg_ext_pol = 1'b1; ext_clamp_in = 1'b0; tick(40);

    tag = "RND";
    for (int l = 0; l < 300; l++) begin
      int p = $urandom_range(0, 30);
      int d = ($urandom_range(0, 7) == 0) ? 0 : $urandom_range(1, 30);
      set_cfg(p, d, $urandom_range(0, 1), $urandom_range(0, 1));
      if ($urandom_range(0, 9) == 0) begin
        cfg_ext_mode = 1'b1; cfg_ext_pol = $urandom_range(0, 1);
      end else cfg_ext_mode = 1'b0;
      ext_clamp_in = $urandom_range(0, 1);
      if ($urandom_range(0, 19) == 0) begin
        tick(4); cfg_hs_pol = !cfg_hs_pol; tick(4);
      end
      line($urandom_range(2, 8), $urandom_range(3, p + d + 8));
    end
    cfg_ext_mode = 1'b0;
    tick(80);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule